// File: doc/BRIEF.md
# Galois Shift-Register Pseudonoise Bit Source

This block produces a serial stream of pseudorandom bits for a link test or a bit-error measurement. A 15-bit shift register with a Galois-style feedback tap between its two upper bits steps once per clock. Each step sends out the register's top bit. The register cycles through every non-zero 15-bit value before it repeats, so the stream has period 32767.

The seed comes from a free-running tick counter that advances on each tick-enable pulse. When a request arrives, the counter value is doubled and one is added. The low 15 bits of that result are loaded as the seed. Because the result is always odd, the loaded state is never zero, and a zero state would lock the register. A request is a single-cycle start pulse that carries the packet length in bits. The block then emits exactly that many bits on consecutive clocks and signals completion with a one-cycle done pulse.

Top module: `pn_bit_source`

## Requirements
- R1: After synchronous reset, bit_valid and done are 0 and the tick counter is 0, so a request with no tick pulse since reset loads seed 1.
- R2: A start accepted at a clock edge loads seed = ((2*T)+1) mod 2^15, where T is the tick counter value before that edge. T equals the number of earlier edges with tick_en high, counted modulo 2^TICK_W.
- R3: Each busy cycle, bit_out is register bit 14. The next state is {s[13]^s[14], s[12:0], s[14]}.
- R4: With seed 000000010101001, the first 16 output bits are 0,0,0,0,0,0,0,1,1,0,0,1,1,1,0,0.
- R5: A start with length N>0 gives exactly N cycles with bit_valid high. These cycles are consecutive and begin in the cycle after the start edge.
- R6: done is high for exactly one cycle. That cycle directly follows the last valid bit. For N=0 it is the cycle after the start edge, and no bit is emitted.
- R7: A start pulse while busy is ignored: the running packet keeps its length, bits and done timing.
- R8: The tick counter wraps modulo 2^TICK_W, and the seed after a wrap follows the wrapped value.
- R9: The register never holds zero while busy. The stream repeats with period 32767, and each full period holds 16384 ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Advances the tick counter by one |
| start | input | 1 | Request pulse, accepted only when idle |
| pkt_len | input | LEN_W | Number of bits to emit, sampled with start |
| bit_out | output | 1 | Serial pseudonoise bit |
| bit_valid | output | 1 | bit_out carries a packet bit |
| done | output | 1 | One-cycle pulse after the last bit |

## Verification
The stream is checked against a known reference trace, and against seeds taken from a zero counter, a small counter and a counter above 2^14. Together these separate a correct update rule from a wrong tap or shift direction, and separate a correct seed map from one that drops the forced low 1 or truncates at the wrong width. A narrow-counter copy of the block is driven past its wrap point, so a wrapped counter can be told apart from a saturating one. Zero-length requests and start pulses that arrive while busy test the length and done logic. A request longer than one full period shows whether the stream repeats at 32767 with the expected balance of ones and zeros.

// File: rtl/pn_bit_source.sv
module pn_bit_source #(
  parameter int SR_W   = 15,
  parameter int TICK_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             start,
  input  logic [LEN_W-1:0] pkt_len,
  output logic             bit_out,
  output logic             bit_valid,
  output logic             done
);

  logic [TICK_W-1:0] tick_q;
  logic [SR_W-1:0]   sr_q, sr_nxt, seed;
  logic [LEN_W-1:0]  left_q;
  logic              busy_q, done_q, accept;

  assign seed   = SR_W'({tick_q, 1'b1});
  assign sr_nxt = {sr_q[SR_W-2] ^ sr_q[SR_W-1], sr_q[SR_W-3:0], sr_q[SR_W-1]};
  assign accept = start && !busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q <= '0;
      sr_q   <= SR_W'(1);
      left_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (tick_en) tick_q <= tick_q + 1'b1;
      if (accept) begin
        if (pkt_len != '0) begin
          busy_q <= 1'b1;
          sr_q   <= seed;
          left_q <= pkt_len;
        end else begin
          done_q <= 1'b1;
        end
      end else if (busy_q) begin
        sr_q   <= sr_nxt;
        left_q <= left_q - 1'b1;
        if (left_q == LEN_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign bit_out   = busy_q & sr_q[SR_W-1];
  assign bit_valid = busy_q;
  assign done      = done_q;

  // R8
  tick_step_chk: assert property (@(posedge clk) disable iff (rst)
    tick_en |=> tick_q == TICK_W'($past(tick_q) + 1'b1));

  // R9
  state_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> sr_q != '0);

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && left_q != LEN_W'(1)) |=> busy_q);

  // R5
  count_down_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && left_q != LEN_W'(1)) |=> left_q == LEN_W'($past(left_q) - 1'b1));

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !busy_q);

  // R3
  rotate_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && left_q != LEN_W'(1)) |=> sr_q[0] == $past(sr_q[SR_W-1]));

endmodule

// File: tb/test_pn_bit_source.sv
`timescale 1ns/1ps
module test_pn_bit_source;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_en = 1'b0;
  logic start = 1'b0;
  logic [15:0] pkt_len = '0;
  logic bit_out, bit_valid, done;
  logic n_bit, n_valid, n_done;

  always #4 clk = ~clk;

  pn_bit_source i_pn_bit_source (
    .clk(clk), .rst(rst), .tick_en(tick_en), .start(start), .pkt_len(pkt_len),
    .bit_out(bit_out), .bit_valid(bit_valid), .done(done));

  pn_bit_source #(.TICK_W(8)) i_pn_bit_source_w (
    .clk(clk), .rst(rst), .tick_en(tick_en), .start(start), .pkt_len(pkt_len),
    .bit_out(n_bit), .bit_valid(n_valid), .done(n_done));

  int nchk = 0;
  int nfail = 0;
  logic [31:0] tick_w = 0;
  int tick_n = 0;
  bit exp_q[$];
  bit rx_log[$];
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [14:0] step(input logic [14:0] s);
    return {s[13] ^ s[14], s[12:0], s[14]};
  endfunction

  function automatic logic [14:0] seed_of(input logic [31:0] t);
    logic [31:0] v;
    v = t * 2 + 1;
    return v[14:0];
  endfunction

  // scoreboard monitor: pops expected bits as the design emits them
  always @(negedge clk) begin
    if (!rst && bit_valid) begin
      rx_log.push_back(bit_out);
      if (exp_q.size() == 0) chk(1'b0, "R5 unexpected bit", 1, 0);
      else begin
        bit e;
        e = exp_q.pop_front();
        chk(bit_out == e, "R3 stream bit", int'(bit_out), int'(e));
      end
    end
  end

  task automatic pulse_ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
    tick_w += n;
    tick_n = (tick_n + n) % 256;
  endtask

  task automatic run_pkt(input int len, input bit disturb, input bit narrow);
    logic [14:0] s, sn;
    s  = seed_of(tick_w);
    sn = seed_of(32'(tick_n));
    rx_log.delete();
    for (int k = 0; k < len; k++) begin
      exp_q.push_back(s[14]);
      s = step(s);
    end
    @(negedge clk);
    pkt_len = 16'(len);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < len; k++) begin
      if (!bit_valid) chk(1'b0, "R5 valid run", 0, 1);
      else nchk++;
      if (narrow) begin
        chk(n_valid && n_bit == sn[14], "R8 narrow counter bit", int'(n_bit), int'(sn[14]));
        sn = step(sn);
      end
      if (disturb && k == 4) begin start = 1'b1; pkt_len = 16'd3; end
      if (disturb && k == 5) start = 1'b0;
      @(negedge clk);
    end
    chk(done && !bit_valid, "R6 done after last bit", int'(done), 1);
    chk(exp_q.size() == 0, "R5 bit count", exp_q.size(), 0);
    @(negedge clk);
    chk(!done, "R6 done single cycle", int'(done), 0);
  endtask

  initial begin
    #(8 * 190000);
    if (!finished) begin
      chk(1'b0, "watchdog", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!bit_valid && !done, "R1 reset outputs", int'(bit_valid | done), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!bit_valid && !done, "R1 idle after reset", int'(bit_valid | done), 0);

    // R1 R2: counter at zero gives seed 1
    run_pkt(16, 0, 1);

    // R4: reference trace from seed 169 (tick 84)
    pulse_ticks(84);
    run_pkt(16, 0, 1);
    begin
      bit ref_bits[16] = '{0,0,0,0,0,0,0,1,1,0,0,1,1,1,0,0};
      for (int i = 0; i < 16; i++)
        chk(rx_log.size() > i && rx_log[i] == ref_bits[i], "R4 reference trace",
            rx_log.size() > i ? int'(rx_log[i]) : -1, int'(ref_bits[i]));
    end

    // R6: zero length request
    @(negedge clk);
    pkt_len = 16'd0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done && !bit_valid, "R6 zero length done", int'(done), 1);
    @(negedge clk);
    chk(!done && !bit_valid, "R6 zero length no bits", int'(done | bit_valid), 0);

    // R7: start while busy ignored
    run_pkt(20, 1, 1);

    // R8: narrow counter wraps past 255
    pulse_ticks(216);
    run_pkt(40, 0, 1);

    // R2: counter above 2^14 truncates to 15 bits
    pulse_ticks(16400);
    run_pkt(30, 0, 0);

    // R9: period and balance
    run_pkt(32787, 0, 0);
    begin
      int ones = 0;
      for (int i = 0; i < 32767; i++) ones += int'(rx_log[i]);
      chk(ones == 16384, "R9 ones per period", ones, 16384);
      for (int i = 0; i < 20; i++)
        chk(rx_log[i] == rx_log[i + 32767], "R9 period 32767",
            int'(rx_log[i + 32767]), int'(rx_log[i]));
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule